// File: doc/BRIEF.md
# Two-Bit Branch Direction Predictor

This block guesses whether a conditional branch will be taken. It holds a table of 2-bit entries. Each entry is chosen by a field of low-order bits of the branch instruction address. A fetch stage presents an address on the lookup port and gets back, in the same cycle, a taken or not-taken guess and the raw 2-bit entry behind it. When the branch later resolves, the execute stage presents the branch address and the real outcome on the update port, and the chosen entry is rewritten on the next clock edge.

The entries follow a four-state machine that has two strong states and two weak states. A strong state needs two opposing outcomes in a row before its prediction flips. A weak state is unstable: the next outcome, whatever it is, sends it straight to the strong state in that direction. It does not step one place as a saturating counter would. Both weak states sit between the two strong ones, but they carry opposite predictions.

Top module: `bpred_2bit`

## Requirements
- R1: The entry encoding is 00 strong not-taken, 01 weak not-taken, 10 weak taken and 11 strong taken. `lk_state` shows the entry selected by `lk_addr`, and `lk_taken` is 1 exactly when that entry is 10 or 11.
- R2: A clock edge with `rst` high sets every entry to 01.
- R3: An update with outcome taken on an entry holding 01 or 10 leaves it at 11.
- R4: An update with outcome not-taken on an entry holding 01 or 10 leaves it at 00.
- R5: An entry at 00 stays at 00 on a not-taken update, and an entry at 11 stays at 11 on a taken update.
- R6: A taken update moves 00 to 01, and a not-taken update moves 11 to 10.
- R7: The entry index is address bits [7:2] with the default 64-entry depth. Addresses that differ only in bits [1:0] or above bit 7 share one entry.
- R8: A clock edge with `upd_valid` low changes no entry.
- R9: When a lookup and an update select the same entry in one cycle, the lookup returns the value held before the update. The new value is visible from the next cycle on.
- R10: The lookup outputs depend combinationally on `lk_addr` and the stored entries, and need no clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lk_addr | input | ADDR_W | Fetch address to predict |
| lk_taken | output | 1 | Predicted direction, 1 = taken |
| lk_state | output | 2 | Entry selected by lk_addr |
| upd_valid | input | 1 | Resolved branch present |
| upd_addr | input | ADDR_W | Address of the resolved branch |
| upd_taken | input | 1 | Real outcome, 1 = taken |

## Verification
Directed sequences drive one entry through each of its eight state-and-outcome pairs. This separates the jump out of a weak state from a one-step counter move, and separates the two strong-state hold cases from the two strong-state leave cases. Addresses that differ only in bits outside [7:2] show whether the index field is the right one. A lookup on the same index as an update in the same cycle shows whether the read bypasses the write. A long pseudo-random phase uses a small address pool, so that collisions and aliasing happen often and idle cycles are mixed with updates. A behavioural model is compared against both lookup outputs on every cycle.

// File: rtl/bpred_pkg.sv
package bpred_pkg;

  typedef enum logic [1:0] {
    ST_NT = 2'b00,
    WK_NT = 2'b01,
    WK_T  = 2'b10,
    ST_T  = 2'b11
  } ctr_t;

  // next entry after a resolved outcome: weak states resolve to a strong one
  function automatic ctr_t ctr_next(input ctr_t cur, input logic taken);
    ctr_t nxt;
    unique case (cur)
      ST_NT:   nxt = taken ? WK_NT : ST_NT;
      WK_NT:   nxt = taken ? ST_T  : ST_NT;
      WK_T:    nxt = taken ? ST_T  : ST_NT;
      default: nxt = taken ? ST_T  : WK_T;
    endcase
    return nxt;
  endfunction

  function automatic logic ctr_predict(input ctr_t cur);
    return (cur == WK_T) || (cur == ST_T);
  endfunction

endpackage

// File: rtl/bpred_index.sv
module bpred_index #(
  parameter int ADDR_W  = 32,
  parameter int IDX_LSB = 2,
  parameter int IDX_W   = 6
) (
  input  logic [ADDR_W-1:0] addr,
  output logic [IDX_W-1:0]  idx
);
  assign idx = addr[IDX_LSB +: IDX_W];

  logic unused_addr_bits;
  assign unused_addr_bits = ^addr;
endmodule

// File: rtl/bpred_table.sv
module bpred_table
  import bpred_pkg::*;
#(
  parameter int DEPTH = 64,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [IDX_W-1:0] rd_idx,
  output ctr_t             rd_data,
  input  logic [IDX_W-1:0] old_idx,
  output ctr_t             old_data,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  ctr_t             wr_data
);
  ctr_t mem [DEPTH];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= WK_NT;
    end else if (wr_en) begin
      mem[wr_idx] <= wr_data;
    end
  end

  assign rd_data  = mem[rd_idx];
  assign old_data = mem[old_idx];

  // R8: a written entry holds the written value one edge later
  assert_write_lands_R8: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> mem[$past(wr_idx)] == $past(wr_data));

  // R8: with no write, the entry read at an index is unchanged
  assert_idle_keeps_R8: assert property (@(posedge clk) disable iff (rst)
    !wr_en |=> mem[$past(rd_idx)] == $past(rd_data));
endmodule

// File: rtl/bpred_update.sv
module bpred_update
  import bpred_pkg::*;
(
  input  ctr_t cur,
  input  logic taken,
  output ctr_t nxt
);
  assign nxt = ctr_next(cur, taken);
endmodule

// File: rtl/bpred_2bit.sv
module bpred_2bit
  import bpred_pkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int DEPTH   = 64,
  parameter int IDX_LSB = 2,
  localparam int IDX_W  = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] lk_addr,
  output logic              lk_taken,
  output logic [1:0]        lk_state,
  input  logic              upd_valid,
  input  logic [ADDR_W-1:0] upd_addr,
  input  logic              upd_taken
);
  logic [IDX_W-1:0] lk_idx, upd_idx;
  ctr_t lk_entry, upd_old, upd_new;

  bpred_index #(.ADDR_W(ADDR_W), .IDX_LSB(IDX_LSB), .IDX_W(IDX_W)) u_lk_idx (
    .addr(lk_addr), .idx(lk_idx));
  bpred_index #(.ADDR_W(ADDR_W), .IDX_LSB(IDX_LSB), .IDX_W(IDX_W)) u_upd_idx (
    .addr(upd_addr), .idx(upd_idx));

  bpred_table #(.DEPTH(DEPTH)) u_table (
    .clk(clk), .rst(rst),
    .rd_idx(lk_idx), .rd_data(lk_entry),
    .old_idx(upd_idx), .old_data(upd_old),
    .wr_en(upd_valid), .wr_idx(upd_idx), .wr_data(upd_new));

  bpred_update u_update (.cur(upd_old), .taken(upd_taken), .nxt(upd_new));

  assign lk_state = lk_entry;
  assign lk_taken = ctr_predict(lk_entry);

  // named events for the checks below
  logic upd_from_weak, upd_from_strong_hold;
  assign upd_from_weak        = upd_valid && (upd_old == WK_NT || upd_old == WK_T);
  assign upd_from_strong_hold = upd_valid &&
                                ((upd_old == ST_T && upd_taken) || (upd_old == ST_NT && !upd_taken));

  assert_weak_to_taken_R3: assert property (@(posedge clk) disable iff (rst)
    upd_from_weak && upd_taken |-> upd_new == ST_T);
  assert_weak_to_nottaken_R4: assert property (@(posedge clk) disable iff (rst)
    upd_from_weak && !upd_taken |-> upd_new == ST_NT);
  assert_strong_hold_R5: assert property (@(posedge clk) disable iff (rst)
    upd_from_strong_hold |-> upd_new == upd_old);
  assert_reset_value_R2: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> lk_state == 2'b01);
  assert_same_slot_old_R9: assert property (@(posedge clk) disable iff (rst)
    upd_valid && (lk_idx == upd_idx) |-> lk_state == upd_old);
endmodule

// File: tb/tb_bpred_2bit.sv
module tb_bpred_2bit;
  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W = 32;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [ADDR_W-1:0] lk_addr = '0;
  logic lk_taken;
  logic [1:0] lk_state;
  logic upd_valid = 1'b0;
  logic [ADDR_W-1:0] upd_addr = '0;
  logic upd_taken = 1'b0;

  int checks = 0;
  int errors = 0;
  int model [64];

  always #(CLK_PERIOD/2) clk = ~clk;

  bpred_2bit dut (.clk(clk), .rst(rst), .lk_addr(lk_addr), .lk_taken(lk_taken),
    .lk_state(lk_state), .upd_valid(upd_valid), .upd_addr(upd_addr), .upd_taken(upd_taken));

  function automatic int slot(input logic [ADDR_W-1:0] a);
    return (a / 4) % 64;
  endfunction

  task automatic compare(input string req);
    int exp_s = model[slot(lk_addr)];
    int exp_t = (exp_s >= 2) ? 1 : 0;
    checks++;
    if (int'(lk_state) != exp_s || int'(lk_taken) != exp_t) begin
      errors++;
      $display("FAIL %s addr=%h state=%0d taken=%0d expected state=%0d taken=%0d",
               req, lk_addr, lk_state, lk_taken, exp_s, exp_t);
    end
  endtask

  // one cycle: drive, check the lookup before the edge, advance the model
  task automatic step(input logic [ADDR_W-1:0] la, input logic uv,
                      input logic [ADDR_W-1:0] ua, input logic ut, input string req);
    @(negedge clk);
    lk_addr = la; upd_valid = uv; upd_addr = ua; upd_taken = ut;
    #1;
    compare(req);
    if (uv) begin
      int m = model[slot(ua)];
      if (ut) model[slot(ua)] = (m == 0) ? 1 : 3;
      else    model[slot(ua)] = (m == 3) ? 2 : 0;
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1'b1; upd_valid = 1'b0;
    @(negedge clk); @(negedge clk); rst = 1'b0;
    foreach (model[i]) model[i] = 1;
  endtask

  // set entry of address a to state s from reset value 01
  task automatic force_state(input logic [ADDR_W-1:0] a, input int s);
    case (s)
      0: step(a, 1, a, 0, "R4");
      2: begin step(a, 1, a, 1, "R3"); step(a, 1, a, 0, "R6"); end
      3: step(a, 1, a, 1, "R3");
      default: ;
    endcase
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [ADDR_W-1:0] a = 32'h0000_0010;
    do_reset();
    // R2: all entries 01 after reset
    for (int i = 0; i < 64; i++) step(i * 4, 0, 0, 0, "R2");
    // R10, R1: lookup changes within the cycle
    step(a, 0, 0, 0, "R10");
    // every state/outcome pair on one entry
    for (int s = 0; s < 4; s++) begin
      for (int t = 0; t < 2; t++) begin
        do_reset();
        force_state(a, s);
        step(a, 1, a, t[0], "R9");     // same-cycle lookup sees old value
        if (s == 1 || s == 2) step(a, 0, 0, 0, t ? "R3" : "R4");
        else if ((s == 0 && t == 0) || (s == 3 && t == 1)) step(a, 0, 0, 0, "R5");
        else step(a, 0, 0, 0, "R6");
        step(a, 0, 0, 0, "R1");
      end
    end
    // R7: aliasing addresses share the slot, neighbours do not
    do_reset();
    step(32'h0000_0010, 1, 32'hABCD_0013, 1, "R7");
    step(32'h5500_0111, 0, 0, 0, "R7");
    step(32'h0000_0014, 0, 0, 0, "R7");
    step(32'h0000_000C, 0, 0, 0, "R7");
    // R8: idle cycles with changing addresses on the update port
    for (int i = 0; i < 8; i++) step(32'h10, 0, i * 4, i[0], "R8");
    step(32'h10, 0, 0, 0, "R8");
    // random phase over a small pool
    for (int i = 0; i < 4000; i++) begin
      logic [ADDR_W-1:0] la = {$urandom} & 32'h0300_003F;
      logic [ADDR_W-1:0] ua = ($urandom % 3 == 0) ? la : ({$urandom} & 32'h0C00_003F);
      step(la, ($urandom % 4) != 0, ua, $urandom % 2, "R1");
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule